// File: doc/BRIEF.md
# Five-Channel Timer Register Interface

This block sits between a 32-bit word-access register bus and five timer channels. It decodes a sparse register window and turns bus writes into single-cycle write strobes toward each channel's control and initial-count registers. It also returns the channel's control, initial-count and live count values on reads. The counting itself lives in the channel blocks. They report back through these readback buses, through a one-cycle zero pulse per channel, and through an interrupt-enable level per channel.

The block owns one shared register, the interrupt status word, which has one sticky flag per channel. Software clears a flag by writing a one to its bit. Each channel's interrupt line is the flag ANDed with that channel's enable, and it is registered so that it changes only on a clock edge. A watchdog control word sits in the same window. It can be read and holds a fixed reset pattern, and writes to it change nothing. Only whole, word-aligned accesses are decoded. Any other access, and any offset outside the map, reads as zero and has no effect when written.

Top module: `tmr_regif`

## Requirements
- R1: A write with `bus_wr` high to a channel control offset (channel 0: 0x000, 1: 0x004, 2: 0x020, 3: 0x024, 4: 0x040) raises only `ch_ctrl_we[c]` in that same cycle, with `ch_wdata` equal to `bus_wdata`.
- R2: A write to a channel initial-count offset (channel 0: 0x008, 1: 0x00C, 2: 0x028, 3: 0x02C, 4: 0x048) raises only `ch_init_we[c]` in that same cycle.
- R3: A read with `bus_rd` high presents the addressed word on `bus_rdata` in the next cycle. Control offsets return `ch_ctrl_val` slice c, initial-count offsets return `ch_init_val` slice c, and count offsets (channel 0: 0x010, 1: 0x014, 2: 0x030, 3: 0x034, 4: 0x050) return `ch_count_val` slice c. Slice c is bits [32c+31:32c]. In a cycle after no read, `bus_rdata` is 0.
- R4: A write to a count offset raises no strobe and leaves the status word unchanged.
- R5: A pulse on `ch_zero[i]` sets status bit i at the next edge, and the bit stays set until it is cleared. Reading 0x018 returns the status in bits [4:0] and zeros in bits [31:5].
- R6: A write to 0x018 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R7: When `ch_zero[i]` and a clear of bit i fall in the same cycle, bit i ends up set.
- R8: At each edge, `irq[i]` takes the updated status bit i ANDed with `ch_irq_en[i]` as sampled at that edge.
- R9: Reading 0x01C returns 0x00000400, both before and after any write to 0x01C.
- R10: Offsets outside the map (for example 0x038, 0x03C, 0x044, 0x04C, 0x054, 0x058, 0xFFC) read as 0, and writes to them raise no strobe and leave the status unchanged.
- R11: An access with `bus_addr[1:0]` not equal to 0 is treated as unmapped: it raises no strobe, clears nothing and reads as 0.
- R12: While `rst_n` is low at an edge, the status word, `irq` and `bus_rdata` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read request |
| ch_wdata | output | 32 | Write data forwarded to the channels |
| ch_ctrl_we | output | 5 | Per-channel control write strobe |
| ch_init_we | output | 5 | Per-channel initial-count write strobe |
| ch_ctrl_val | input | 160 | Control readback, 32 bits per channel |
| ch_init_val | input | 160 | Initial-count readback, 32 bits per channel |
| ch_count_val | input | 160 | Live count readback, 32 bits per channel |
| ch_zero | input | 5 | Per-channel reached-zero pulse |
| ch_irq_en | input | 5 | Per-channel interrupt enable level |
| irq | output | 5 | Per-channel interrupt line |

## Verification
The only state is the status word and the interrupt lines derived from it. A wrong flag shows on `irq` at the very next edge whenever that channel is enabled, and on `bus_rdata` one cycle after any status read. A decode fault shows at once as a stray or missing strobe in the same cycle as the write. A wrong read steer shows one cycle after the read. The bench therefore compares strobes, interrupt lines and read data with a behavioural model on every cycle, so a divergence is reported within one or two cycles of its cause.

// File: rtl/tmr_regif_pkg.sv
// Package: shared types and register-map arithmetic for the timer register
// interface. Assumes channels are laid out in pairs inside 32-byte groups.
package tmr_regif_pkg;

    // Width of the channel index carried with a decoded access.
    localparam int CH_IDX_W = 8;

    // Map geometry (byte offsets).
    localparam int unsigned GROUP_STRIDE = 32'h20;
    localparam int unsigned LANE_STRIDE  = 32'h4;
    localparam int unsigned INIT_BASE    = 32'h8;
    localparam int unsigned COUNT_BASE   = 32'h10;
    localparam int unsigned STATUS_OFS   = 32'h18;
    localparam int unsigned WDOG_OFS     = 32'h1C;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_INIT,
        REG_COUNT,
        REG_STATUS,
        REG_WDOG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CH_IDX_W-1:0]   ch;
    } reg_sel_t;

    // Byte offset of a channel's control word.
    function automatic int unsigned ctrl_offset(int unsigned ch);
        return (ch / 2) * GROUP_STRIDE + (ch % 2) * LANE_STRIDE;
    endfunction

    // Byte offset of a channel's initial-count word.
    function automatic int unsigned init_offset(int unsigned ch);
        return ctrl_offset(ch) + INIT_BASE;
    endfunction

    // Byte offset of a channel's live count word.
    function automatic int unsigned count_offset(int unsigned ch);
        return ctrl_offset(ch) + COUNT_BASE;
    endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
// Address decoder: classifies a byte offset into a register kind and channel.
// Assumes only word-aligned offsets are legal; anything else decodes to none.
module tmr_addr_decode
    import tmr_regif_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    logic             aligned;
    logic [NUM_CH-1:0] hit_ctrl;
    logic [NUM_CH-1:0] hit_init;
    logic [NUM_CH-1:0] hit_count;

    assign aligned = (addr[1:0] == 2'b00);

    // Per-channel offset comparators, one set per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign hit_ctrl[c]  = aligned && (addr == ADDR_W'(ctrl_offset(c)));
        assign hit_init[c]  = aligned && (addr == ADDR_W'(init_offset(c)));
        assign hit_count[c] = aligned && (addr == ADDR_W'(count_offset(c)));
    end

    // Fold the comparator hits into one decoded selection.
    always_comb begin
        sel.kind = REG_NONE;
        sel.ch   = '0;
        if (aligned && addr == ADDR_W'(STATUS_OFS)) begin
            sel.kind = REG_STATUS;
        end else if (aligned && addr == ADDR_W'(WDOG_OFS)) begin
            sel.kind = REG_WDOG;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (hit_ctrl[c]) begin
                    sel.kind = REG_CTRL;
                    sel.ch   = CH_IDX_W'(c);
                end else if (hit_init[c]) begin
                    sel.kind = REG_INIT;
                    sel.ch   = CH_IDX_W'(c);
                end else if (hit_count[c]) begin
                    sel.kind = REG_COUNT;
                    sel.ch   = CH_IDX_W'(c);
                end
            end
        end
    end

    // A misaligned offset never selects a register (R11).
    always_comb begin
        if (!aligned) assert_misaligned_none_R11: assert (sel.kind == REG_NONE);
    end

endmodule

// File: rtl/tmr_irq_status.sv
// Interrupt status word: one sticky flag per channel, set by zero pulses,
// cleared by write-one; registered interrupt lines gated by enables.
// Assumes set and clear masks are valid for exactly one cycle each.
module tmr_irq_status #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_mask,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] irq_en,
    output logic [NUM_CH-1:0] status_q,
    output logic [NUM_CH-1:0] irq_q
);

    logic [NUM_CH-1:0] status_nxt;

    // Next flags: clear requested bits first, then let new events win.
    always_comb status_nxt = (status_q & ~clr_mask) | set_mask;

    // Flag and interrupt registers, both updated from the same next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= '0;
        end else begin
            status_q <= status_nxt;
            irq_q    <= status_nxt & irq_en;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[i] |=> status_q[i]);
        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !set_mask[i]) |=> !status_q[i]);
        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_mask[i] && !set_mask[i]) |=> $stable(status_q[i]));
        assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q[i] |-> status_q[i]);
        assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en[i] |=> !irq_q[i]);
    end

endmodule

// File: rtl/tmr_read_mux.sv
// Read path: selects the addressed word and registers it for one cycle.
// Assumes readback buses are stable in the cycle of the read request.
module tmr_read_mux
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  reg_sel_t                 sel,
    input  logic [NUM_CH*DATA_W-1:0] ctrl_val,
    input  logic [NUM_CH*DATA_W-1:0] init_val,
    input  logic [NUM_CH*DATA_W-1:0] count_val,
    input  logic [NUM_CH-1:0]        status,
    input  logic [DATA_W-1:0]        wdog,
    output logic [DATA_W-1:0]        rdata_q
);

    logic [DATA_W-1:0] rd_val;

    // Pick the word named by the decoded selection.
    always_comb begin
        rd_val = '0;
        case (sel.kind)
            REG_STATUS: rd_val = DATA_W'(status);
            REG_WDOG:   rd_val = wdog;
            REG_CTRL, REG_INIT, REG_COUNT: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (sel.ch == CH_IDX_W'(c)) begin
                        if (sel.kind == REG_CTRL)
                            rd_val = ctrl_val[c*DATA_W +: DATA_W];
                        else if (sel.kind == REG_INIT)
                            rd_val = init_val[c*DATA_W +: DATA_W];
                        else
                            rd_val = count_val[c*DATA_W +: DATA_W];
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    // Read data register: valid the cycle after a request, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
        else            rdata_q <= '0;
    end

    assert_idle_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata_q == '0));

endmodule

// File: rtl/tmr_regif.sv
// Top: register interface for a set of timer channels. Decodes the bus,
// forwards write strobes, owns the status word and a write-protected
// watchdog control word. Assumes one access per cycle, word granularity.
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int          NUM_CH     = 5,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter logic [31:0] WDOG_RESET = 32'h0000_0400
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [DATA_W-1:0]        ch_wdata,
    output logic [NUM_CH-1:0]        ch_ctrl_we,
    output logic [NUM_CH-1:0]        ch_init_we,
    input  logic [NUM_CH*DATA_W-1:0] ch_ctrl_val,
    input  logic [NUM_CH*DATA_W-1:0] ch_init_val,
    input  logic [NUM_CH*DATA_W-1:0] ch_count_val,
    input  logic [NUM_CH-1:0]        ch_zero,
    input  logic [NUM_CH-1:0]        ch_irq_en,
    output logic [NUM_CH-1:0]        irq
);

    reg_sel_t          sel;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] status;
    logic [DATA_W-1:0] wdog_q;

    tmr_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Write steering: one strobe per channel and register kind.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign ch_ctrl_we[c] = bus_wr && (sel.kind == REG_CTRL) && (sel.ch == CH_IDX_W'(c));
        assign ch_init_we[c] = bus_wr && (sel.kind == REG_INIT) && (sel.ch == CH_IDX_W'(c));
    end
    assign ch_wdata = bus_wdata;

    // Clear mask: write-one-to-clear on the status word only.
    always_comb clr_mask = (bus_wr && sel.kind == REG_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;

    tmr_irq_status #(.NUM_CH(NUM_CH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (ch_zero),
        .clr_mask (clr_mask),
        .irq_en   (ch_irq_en),
        .status_q (status),
        .irq_q    (irq)
    );

    // Watchdog control word: loads its reset pattern and ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_q <= DATA_W'(WDOG_RESET);
        else        wdog_q <= wdog_q;
    end

    tmr_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .sel       (sel),
        .ctrl_val  (ch_ctrl_val),
        .init_val  (ch_init_val),
        .count_val (ch_count_val),
        .status    (status),
        .wdog      (wdog_q),
        .rdata_q   (bus_rdata)
    );

    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_ctrl_we, ch_init_we}));
    assert_misaligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] != 2'b00) |-> (ch_ctrl_we == '0 && ch_init_we == '0));
    assert_wdog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(WDOG_OFS)) |=> (bus_rdata == DATA_W'(WDOG_RESET)));
    assert_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0 && bus_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ro
        assert_count_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(count_offset(c))) |->
            (ch_ctrl_we == '0 && ch_init_we == '0));
    end

endmodule

// File: tb/tmr_regif_tb.sv
// Bench: behavioural reference model updated each posedge, compared with
// the design every negedge before the next stimulus is applied.
module tmr_regif_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    wire  [31:0]  bus_rdata, ch_wdata;
    wire  [4:0]   ch_ctrl_we, ch_init_we, irq;
    logic [159:0] ch_ctrl_val = '0, ch_init_val = '0, ch_count_val = '0;
    logic [4:0]   ch_zero = '0, ch_irq_en = '0;

    int    errors = 0, checks = 0;
    string cur_req = "R12";
    bit    done = 1'b0;

    logic [4:0]  m_status = '0, m_irq = '0;
    logic [31:0] m_rdata = '0;

    always #4 clk = ~clk;

    tmr_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_wdata(ch_wdata), .ch_ctrl_we(ch_ctrl_we), .ch_init_we(ch_init_we),
        .ch_ctrl_val(ch_ctrl_val), .ch_init_val(ch_init_val),
        .ch_count_val(ch_count_val), .ch_zero(ch_zero), .ch_irq_en(ch_irq_en),
        .irq(irq)
    );

    function automatic logic [31:0] model_read(logic [11:0] a);
        case (a)
            12'h000: return ch_ctrl_val[31:0];
            12'h004: return ch_ctrl_val[63:32];
            12'h020: return ch_ctrl_val[95:64];
            12'h024: return ch_ctrl_val[127:96];
            12'h040: return ch_ctrl_val[159:128];
            12'h008: return ch_init_val[31:0];
            12'h00C: return ch_init_val[63:32];
            12'h028: return ch_init_val[95:64];
            12'h02C: return ch_init_val[127:96];
            12'h048: return ch_init_val[159:128];
            12'h010: return ch_count_val[31:0];
            12'h014: return ch_count_val[63:32];
            12'h030: return ch_count_val[95:64];
            12'h034: return ch_count_val[127:96];
            12'h050: return ch_count_val[159:128];
            12'h018: return {27'd0, m_status};
            12'h01C: return 32'h0000_0400;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [4:0] exp_ctrl_we(logic wr, logic [11:0] a);
        if (!wr) return 5'b0;
        case (a)
            12'h000: return 5'b00001;
            12'h004: return 5'b00010;
            12'h020: return 5'b00100;
            12'h024: return 5'b01000;
            12'h040: return 5'b10000;
            default: return 5'b0;
        endcase
    endfunction

    function automatic logic [4:0] exp_init_we(logic wr, logic [11:0] a);
        if (!wr) return 5'b0;
        case (a)
            12'h008: return 5'b00001;
            12'h00C: return 5'b00010;
            12'h028: return 5'b00100;
            12'h02C: return 5'b01000;
            12'h048: return 5'b10000;
            default: return 5'b0;
        endcase
    endfunction

    // Reference model: advances on each rising edge.
    always @(posedge clk) begin
        logic [4:0] clr;
        if (!rst_n) begin
            m_status = '0; m_irq = '0; m_rdata = '0;
        end else begin
            m_rdata  = bus_rd ? model_read(bus_addr) : 32'h0;
            clr      = (bus_wr && bus_addr == 12'h018) ? bus_wdata[4:0] : 5'b0;
            m_status = (m_status & ~clr) | ch_zero;
            m_irq    = m_status & ch_irq_en;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("irq", {27'd0, irq}, {27'd0, m_irq});
        chk("rdata", bus_rdata, m_rdata);
        chk("ctrl_we", {27'd0, ch_ctrl_we}, {27'd0, exp_ctrl_we(bus_wr, bus_addr)});
        chk("init_we", {27'd0, ch_init_we}, {27'd0, exp_init_we(bus_wr, bus_addr)});
        if (ch_ctrl_we != 0 || ch_init_we != 0) chk("wdata", ch_wdata, bus_wdata);
    endtask

    // One cycle: check the previous cycle's results, then drive the next.
    task automatic cyc(logic wr, logic rd, logic [11:0] a, logic [31:0] d,
                       logic [4:0] z);
        @(negedge clk);
        compare_all();
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ch_zero = z;
    endtask

    task automatic wr_op(logic [11:0] a, logic [31:0] d); cyc(1, 0, a, d, 0); endtask
    task automatic rd_op(logic [11:0] a);                  cyc(0, 1, a, 0, 0); endtask
    task automatic idle();                                 cyc(0, 0, 0, 0, 0); endtask

    initial begin
        logic [11:0] ctrl_ofs [5] = '{12'h000, 12'h004, 12'h020, 12'h024, 12'h040};
        logic [11:0] init_ofs [5] = '{12'h008, 12'h00C, 12'h028, 12'h02C, 12'h048};
        logic [11:0] cnt_ofs  [5] = '{12'h010, 12'h014, 12'h030, 12'h034, 12'h050};
        logic [11:0] bad_ofs  [7] = '{12'h038, 12'h03C, 12'h044, 12'h04C, 12'h054, 12'h058, 12'hFFC};
        for (int c = 0; c < 5; c++) begin
            ch_ctrl_val[c*32 +: 32]  = 32'hC0DE_0000 | c;
            ch_init_val[c*32 +: 32]  = 32'h1A1A_0100 + c;
            ch_count_val[c*32 +: 32] = 32'h0BAD_F000 + 3 * c;
        end
        // R12: reset state
        cur_req = "R12";
        repeat (3) idle();
        @(negedge clk); rst_n = 1'b1;
        idle(); idle();

        cur_req = "R1";
        for (int c = 0; c < 5; c++) wr_op(ctrl_ofs[c], 32'h4000_0000 + c);
        cur_req = "R2";
        for (int c = 0; c < 5; c++) wr_op(init_ofs[c], 32'h0000_1000 * (c + 1));
        cur_req = "R3";
        for (int c = 0; c < 5; c++) begin
            rd_op(ctrl_ofs[c]); rd_op(init_ofs[c]); rd_op(cnt_ofs[c]);
        end
        ch_count_val = {5{32'h5555_AAAA}} ^ ch_count_val;
        for (int c = 0; c < 5; c++) rd_op(cnt_ofs[c]);
        idle();
        cur_req = "R5";
        cyc(0, 0, 0, 0, 5'b10010);
        idle();
        rd_op(12'h018);
        cyc(0, 1, 12'h018, 0, 5'b00001);
        rd_op(12'h018);
        cur_req = "R4";
        for (int c = 0; c < 5; c++) wr_op(cnt_ofs[c], 32'hFFFF_FFFF);
        rd_op(12'h018);
        cur_req = "R6";
        wr_op(12'h018, 32'h0000_0002);
        rd_op(12'h018);
        wr_op(12'h018, 32'h0000_0000);
        rd_op(12'h018);
        wr_op(12'h018, 32'hFFFF_FFFF);
        rd_op(12'h018);
        cur_req = "R7";
        cyc(0, 0, 0, 0, 5'b01100);
        cyc(1, 0, 12'h018, 32'h0000_000C, 5'b00100);
        rd_op(12'h018);
        cur_req = "R8";
        cyc(0, 0, 0, 0, 5'b11111);
        idle();
        ch_irq_en = 5'b10101; idle(); idle();
        ch_irq_en = 5'b01011; idle();
        wr_op(12'h018, 32'h0000_0001);
        idle();
        ch_irq_en = 5'b00000; idle(); idle();
        ch_irq_en = 5'b11111; idle();
        cur_req = "R9";
        rd_op(12'h01C);
        wr_op(12'h01C, 32'h0000_0000);
        rd_op(12'h01C);
        wr_op(12'h01C, 32'hFFFF_FFFF);
        rd_op(12'h01C);
        cur_req = "R10";
        for (int k = 0; k < 7; k++) begin
            wr_op(bad_ofs[k], 32'hFFFF_FFFF);
            rd_op(bad_ofs[k]);
        end
        rd_op(12'h018);
        cur_req = "R11";
        wr_op(12'h019, 32'hFFFF_FFFF);
        wr_op(12'h001, 32'hFFFF_FFFF);
        wr_op(12'h00A, 32'h1234_5678);
        rd_op(12'h002);
        rd_op(12'h01F);
        rd_op(12'h018);
        // Mixed traffic against the model (R3, R5 to R8).
        cur_req = "R3";
        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(0, 23);
            logic [11:0] a;
            if (n == 300) cur_req = "R8";
            if (pick < 5)       a = ctrl_ofs[pick];
            else if (pick < 10) a = init_ofs[pick - 5];
            else if (pick < 15) a = cnt_ofs[pick - 10];
            else if (pick < 19) a = 12'h018;
            else if (pick < 20) a = 12'h01C;
            else if (pick < 22) a = bad_ofs[pick % 7];
            else                a = 12'(12'h018 + $urandom_range(1, 3));
            if (n % 37 == 0) ch_irq_en = 5'($urandom);
            if (n % 11 == 0) ch_count_val[($urandom % 5)*32 +: 32] = $urandom;
            cyc(1'($urandom), 1'($urandom), a, $urandom,
                ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'b0);
        end
        idle(); idle();
        // R12 again: reset mid-operation clears flags and lines
        cur_req = "R12";
        cyc(0, 0, 0, 0, 5'b11111);
        @(negedge clk); compare_all(); rst_n = 1'b0;
        idle(); idle();
        @(negedge clk); rst_n = 1'b1;
        idle(); rd_op(12'h018); idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule